// File: doc/BRIEF.md
# Descriptor-Ring Audio DMA Channel Controller

This block is the control and status engine of one audio bus-master DMA channel. Software places a ring of 32 buffer descriptors in memory, each 8 bytes long, writes the ring's base address and the index of the last descriptor it has filled, then sets the run bit. The channel fetches the control word of the current descriptor through a simple memory read port. It keeps the buffer length and the interrupt-on-completion flag from that word. Each pulse from the sample datapath then completes one buffer and advances the channel around the ring.

When the channel reaches the last filled descriptor it halts and raises status. Software can then append descriptors and rewrite the last-valid index, which restarts the stalled channel. Status flags are cleared by writing ones. One level interrupt request follows the buffer-completion and last-buffer flags, each gated by its own enable bit.

Register offsets, with data right-aligned on `reg_wdata_i`/`reg_rdata_o`: 0x0 descriptor base (dword), 0x4 current index, 0x5 last-valid index, 0x6 status, 0x8 remaining sample count, 0xA prefetch index, 0xB control. Reads are combinational and decode the offset only. Status bits: 0 halted, 1 current-is-last, 2 last-buffer-done, 3 buffer-done, 4 FIFO error. Control bits: 0 run, 1 channel reset, 2 last-buffer interrupt enable, 4 buffer-done interrupt enable.

Top module: `adma_chan`

## Requirements
- R1: A dword write to offset 0x0 stores the base with bits 2:0 forced to zero; writing 0x5555555F reads back 0x55555558.
- R2: After rst_ni the status reads 0x0001, every other register reads 0, irq_o is low and no fetch is requested.
- R3: A fetch holds mem_req_o high with mem_addr_o = base + 8*index + 4 until mem_ack_i. On the ack the count register loads mem_rdata_i[15:0] and bit 31 becomes the interrupt-on-completion flag of the current buffer.
- R4: Writing control with run set while run was clear sets current index 0 and prefetch index 1, clears halted and fetches descriptor 0. Writing control with run clear sets halted and drops any pending fetch.
- R5: An accepted buf_done_i sets status bit 3 when the current buffer's flag is set.
- R6: An accepted buf_done_i with current index equal to last-valid sets status bits 0, 1 and 2 and keeps the index. Otherwise it advances the current index by one (mod 32), sets prefetch to current+1, clears bit 1 and fetches the new descriptor.
- R7: Status bits 2, 3 and 4 clear when written with one; all other status bits ignore writes, so 0xFFFF written to a reset status still reads 0x0001.
- R8: The last-valid index is stored modulo 32. Writing it while run is set, halted is set and the current index differs from the new value advances one buffer, clears bits 0 and 1 and fetches.
- R9: Writing control with bit 1 set returns all channel registers to their reset values, status 0x0001, and drops irq_o.
- R10: irq_o is re-evaluated only in cycles where status bits 4:2 change, to (bit2 and enable bit 2) or (bit3 and enable bit 4); otherwise it holds.
- R11: buf_done_i is ignored while run is clear, while halted is set, or while a fetch is pending.
- R12: When a status bit is set by an event in the same cycle as a write-one-to-clear of that bit, the bit ends set.
- R13: A pulse on fifo_err_i sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| reg_wdata_i | input | 32 | Write data, right-aligned |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, right-aligned |
| mem_req_o | output | 1 | Descriptor control word read request |
| mem_addr_o | output | 32 | Byte address of the control word |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Control word read data |
| buf_done_i | input | 1 | Current buffer finished by the datapath |
| fifo_err_i | input | 1 | FIFO error event from the datapath |
| irq_o | output | 1 | Interrupt request level |

## Verification
A buffer-done pulse and a status write can fall in the same cycle. One sets the buffer-done flag while the other writes a one to clear that same flag. The bench drives both in one cycle on a descriptor whose completion flag is set. It then expects the flag to read back set, the index to have advanced and the interrupt to rise. A second case pulses buffer-done again in the cycle after an advance, while the new fetch is still pending, and expects the index to move only once.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam logic [3:0] OFS_BASE = 4'h0;
  localparam logic [3:0] OFS_CIDX = 4'h4;
  localparam logic [3:0] OFS_LAST = 4'h5;
  localparam logic [3:0] OFS_STS  = 4'h6;
  localparam logic [3:0] OFS_CNT  = 4'h8;
  localparam logic [3:0] OFS_PIDX = 4'hA;
  localparam logic [3:0] OFS_CTL  = 4'hB;

  localparam logic [1:0] SZ_DWORD = 2'd2;

  localparam int ST_HALT = 0;
  localparam int ST_CEL  = 1;
  localparam int ST_LBD  = 2;
  localparam int ST_BD   = 3;
  localparam int ST_FE   = 4;
  localparam int STS_W   = 5;

  localparam int CT_RUN = 0;
  localparam int CT_RST = 1;
  localparam int CT_LIE = 2;
  localparam int CT_BIE = 4;
  localparam logic [7:0] CTL_KEEP = 8'h15;
endpackage

// File: rtl/adma_fetch.sv
module adma_fetch #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cancel_i,
  input  logic [AW-1:0] addr_i,
  input  logic          mem_ack_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          done_o
);
  logic          busy_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      addr_q <= addr_i;
    end else if (mem_ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign mem_req_o  = busy_q;
  assign mem_addr_o = addr_q;
  assign done_o     = busy_q & mem_ack_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !cancel_i && !start_i |=> mem_req_o && $stable(mem_addr_o)); // R3
endmodule

// File: rtl/adma_irq.sv
module adma_irq #(
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [SW-1:0] flags_old_i,
  input  logic [SW-1:0] flags_new_i,
  input  logic          lie_i,
  input  logic          bie_i,
  output logic          irq_o
);
  logic irq_q;

  // flags: [0] last-buffer, [1] buffer-done, [2] fifo error (no enable)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          irq_q <= 1'b0;
    else if (clr_i)                       irq_q <= 1'b0;
    else if (flags_old_i != flags_new_i)  irq_q <= (flags_new_i[0] & lie_i) | (flags_new_i[1] & bie_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/adma_chan.sv
module adma_chan
  import adma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 5,
  parameter int LEN_W = 16,
  parameter int IOC_B = 31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [1:0]  reg_size_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        buf_done_i,
  input  logic        fifo_err_i,
  output logic        irq_o
);
  localparam int DESC_SH  = 3;
  localparam int CTRL_OFS = 4;

  logic [AW-1:0]    base_q, base_n;
  logic [IDX_W-1:0] cidx_q, cidx_n, pidx_q, pidx_n, last_q, last_n;
  logic [STS_W-1:0] sts_q, sts_n;
  logic [7:0]       ctl_q, ctl_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             ioc_q, ioc_n;

  logic wr_base, wr_last, wr_sts, wr_ctl, done_ok;
  logic f_start, f_cancel, f_done, ctl_rst;
  logic [AW-1:0] f_addr;

  assign wr_base = reg_we_i && reg_addr_i == OFS_BASE && reg_size_i == SZ_DWORD;
  assign wr_last = reg_we_i && reg_addr_i == OFS_LAST;
  assign wr_sts  = reg_we_i && reg_addr_i == OFS_STS;
  assign wr_ctl  = reg_we_i && reg_addr_i == OFS_CTL;
  assign done_ok = buf_done_i && ctl_q[CT_RUN] && !sts_q[ST_HALT] && !mem_req_o;

  // Order within a cycle: W1C on old status, datapath events, then register writes.
  always_comb begin
    base_n = base_q; cidx_n = cidx_q; pidx_n = pidx_q; last_n = last_q;
    ctl_n = ctl_q; cnt_n = cnt_q; ioc_n = ioc_q;
    sts_n = sts_q & ~(wr_sts ? {reg_wdata_i[ST_FE:ST_LBD], 2'b00} : '0);
    f_start = 1'b0; f_cancel = 1'b0; ctl_rst = 1'b0;

    if (fifo_err_i) sts_n[ST_FE] = 1'b1;
    if (f_done) begin
      cnt_n = mem_rdata_i[LEN_W-1:0];
      ioc_n = mem_rdata_i[IOC_B];
    end
    if (done_ok) begin
      if (ioc_q) sts_n[ST_BD] = 1'b1;
      if (cidx_q == last_q) begin
        sts_n[ST_HALT] = 1'b1; sts_n[ST_CEL] = 1'b1; sts_n[ST_LBD] = 1'b1;
      end else begin
        cidx_n = cidx_q + 1'b1;
        pidx_n = cidx_n + 1'b1;
        sts_n[ST_CEL] = 1'b0;
        f_start = 1'b1;
      end
    end
    if (wr_base) base_n = {reg_wdata_i[AW-1:3], 3'b000};
    if (wr_last) begin
      last_n = reg_wdata_i[IDX_W-1:0];
      if (ctl_q[CT_RUN] && sts_n[ST_HALT] && cidx_n != last_n) begin
        cidx_n = cidx_n + 1'b1;
        pidx_n = cidx_n + 1'b1;
        sts_n[ST_HALT] = 1'b0; sts_n[ST_CEL] = 1'b0;
        f_start = 1'b1;
      end
    end
    if (wr_ctl) begin
      if (reg_wdata_i[CT_RST]) begin
        base_n = '0; cidx_n = '0; pidx_n = '0; last_n = '0;
        ctl_n = '0; cnt_n = '0; ioc_n = 1'b0;
        sts_n = STS_W'(1);
        f_start = 1'b0; f_cancel = 1'b1; ctl_rst = 1'b1;
      end else begin
        if (!reg_wdata_i[CT_RUN]) begin
          sts_n[ST_HALT] = 1'b1;
          f_cancel = 1'b1;
        end else if (!ctl_q[CT_RUN]) begin
          cidx_n = '0; pidx_n = IDX_W'(1);
          sts_n[ST_HALT] = 1'b0;
          f_start = 1'b1;
        end
        ctl_n = reg_wdata_i[7:0] & CTL_KEEP;
      end
    end
  end

  assign f_addr = base_n + (AW'(cidx_n) << DESC_SH) + AW'(CTRL_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0; cidx_q <= '0; pidx_q <= '0; last_q <= '0;
      sts_q <= STS_W'(1); ctl_q <= '0; cnt_q <= '0; ioc_q <= 1'b0;
    end else begin
      base_q <= base_n; cidx_q <= cidx_n; pidx_q <= pidx_n; last_q <= last_n;
      sts_q <= sts_n; ctl_q <= ctl_n; cnt_q <= cnt_n; ioc_q <= ioc_n;
    end
  end

  adma_fetch #(.AW(AW)) u_fetch (
    .clk_i, .rst_ni,
    .start_i(f_start), .cancel_i(f_cancel), .addr_i(f_addr),
    .mem_ack_i, .mem_req_o, .mem_addr_o, .done_o(f_done)
  );

  adma_irq #(.SW(3)) u_irq (
    .clk_i, .rst_ni,
    .clr_i(ctl_rst),
    .flags_old_i(sts_q[ST_FE:ST_LBD]), .flags_new_i(sts_n[ST_FE:ST_LBD]),
    .lie_i(ctl_n[CT_LIE]), .bie_i(ctl_n[CT_BIE]),
    .irq_o
  );

  always_comb begin
    unique case (reg_addr_i)
      OFS_BASE: reg_rdata_o = 32'(base_q);
      OFS_CIDX: reg_rdata_o = 32'(cidx_q);
      OFS_LAST: reg_rdata_o = 32'(last_q);
      OFS_STS:  reg_rdata_o = 32'(sts_q);
      OFS_CNT:  reg_rdata_o = 32'(cnt_q);
      OFS_PIDX: reg_rdata_o = 32'(pidx_q);
      OFS_CTL:  reg_rdata_o = 32'(ctl_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_DESC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'd4); // R3
  AST_LAST_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ok && cidx_q == last_q && !wr_ctl && !wr_last |=> sts_q[ST_HALT] && sts_q[ST_LBD] && $stable(cidx_q)); // R6
  AST_RUN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl && !reg_wdata_i[CT_RST] && !reg_wdata_i[CT_RUN] |=> sts_q[ST_HALT] && !mem_req_o); // R4
  AST_IRQ_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o != $past(irq_o) |-> sts_q[ST_FE:ST_LBD] != $past(sts_q[ST_FE:ST_LBD]) || $past(ctl_rst)); // R10
  AST_DONE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_done_i && mem_req_o && !wr_last && !wr_ctl |=> $stable(cidx_q)); // R11
endmodule

// File: tb/tb_adma_chan.sv
`timescale 1ns/1ps
module tb_adma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0; logic [3:0] reg_addr = '0; logic [1:0] reg_size = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_ack = 1'b0; logic [31:0] mem_addr, mem_rdata = '0;
  logic buf_done = 1'b0, fifo_err = 1'b0, irq;
  int n_chk = 0, n_err = 0, wait_n = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adma_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_size_i(reg_size), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .buf_done_i(buf_done), .fifo_err_i(fifo_err), .irq_o(irq)
  );

  // descriptor content: length = 3*idx+5, completion flag on even indices
  function automatic logic [31:0] desc(input logic [31:0] a);
    int idx = int'(a[7:3]);
    return {idx[0] == 1'b0, 15'd0, 16'(idx * 3 + 5)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_base, m_faddr; int m_cidx, m_pidx, m_last, m_cnt;
  logic [4:0] m_sts; logic [7:0] m_ctl; bit m_ioc, m_busy, m_irq;
  logic [4:0] s; bit b, rst_hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_cidx = 0; m_pidx = 0; m_last = 0; m_cnt = 0; m_sts = 5'h01;
      m_ctl = 0; m_ioc = 0; m_busy = 0; m_irq = 0; m_faddr = 0;
    end else begin
      s = m_sts; b = m_busy; rst_hit = 0;
      if (reg_we && reg_addr == 4'h6) s = s & ~(reg_wdata[4:0] & 5'h1C);
      if (fifo_err) s[4] = 1;
      if (m_busy && mem_ack) begin m_cnt = mem_rdata[15:0]; b = 0; end
      if (buf_done && m_ctl[0] && !m_sts[0] && !m_busy) begin
        if (m_ioc) s[3] = 1;
        if (m_cidx == m_last) s[2:0] = 3'b111;
        else begin m_cidx = (m_cidx + 1) % 32; m_pidx = (m_cidx + 1) % 32; s[1] = 0; b = 1; end
      end
      if (m_busy && mem_ack) m_ioc = mem_rdata[31];
      if (reg_we && reg_addr == 4'h0 && reg_size == 2) m_base = reg_wdata & ~32'h7;
      if (reg_we && reg_addr == 4'h5) begin
        m_last = reg_wdata % 32;
        if (m_ctl[0] && s[0] && m_cidx != m_last) begin
          m_cidx = (m_cidx + 1) % 32; m_pidx = (m_cidx + 1) % 32; s[1:0] = 0; b = 1;
        end
      end
      if (reg_we && reg_addr == 4'hB) begin
        if (reg_wdata[1]) begin
          m_base = 0; m_cidx = 0; m_pidx = 0; m_last = 0; m_cnt = 0; m_ioc = 0;
          m_ctl = 0; s = 5'h01; b = 0; rst_hit = 1;
        end else begin
          if (!reg_wdata[0]) begin s[0] = 1; b = 0; end
          else if (!m_ctl[0]) begin m_cidx = 0; m_pidx = 1; s[0] = 0; b = 1; end
          m_ctl = reg_wdata[7:0] & 8'h15;
        end
      end
      if (rst_hit) m_irq = 0;
      else if (s[4:2] != m_sts[4:2]) m_irq = (s[2] & m_ctl[2]) | (s[3] & m_ctl[4]);
      if (b && !m_busy || b && (reg_we && (reg_addr == 4'h5 || reg_addr == 4'hB)) || b && buf_done && !m_busy)
        m_faddr = m_base + 32'(m_cidx) * 8 + 4;
      m_busy = b; m_sts = s;
    end
  end

  // per-cycle comparison of the interrupt and memory port (R3, R10)
  always @(negedge clk) if (rst_n && !finished) begin
    chk(irq == m_irq, "R10 irq", irq, m_irq);
    chk(mem_req == m_busy, "R3 req", mem_req, m_busy);
    if (m_busy) chk(mem_addr == m_faddr, "R3 addr", mem_addr, m_faddr);
  end

  // memory responder: ack two cycles after request
  always @(negedge clk) begin
    if (!rst_n) begin mem_ack = 0; wait_n = 0; end
    else if (mem_ack) begin mem_ack = 0; wait_n = 0; end
    else if (mem_req) begin
      wait_n++;
      if (wait_n == 2) begin mem_ack = 1; mem_rdata = desc(mem_addr); end
    end else wait_n = 0;
  end

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_size = sz; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask
  task automatic done_pulse();
    @(negedge clk); buf_done = 1; @(negedge clk); buf_done = 0;
  endtask
  task automatic wait_fetch();
    @(negedge clk); while (mem_req) @(negedge clk);
  endtask
  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    // R2 reset state
    rd(4'h0, 0, "R2 base"); rd(4'h6, 32'h1, "R2 status"); rd(4'hB, 0, "R2 ctl");
    rd(4'h4, 0, "R2 cidx"); chk(irq == 0, "R2 irq", irq, 0);
    // R7 all-ones status write
    wr(4'h6, 2'd1, 32'hFFFF); rd(4'h6, 32'h1, "R7 ignore");
    // R1 base alignment
    wr(4'h0, 2'd2, 32'h5555555F); rd(4'h0, 32'h55555558, "R1 base");
    wr(4'h0, 2'd2, 32'h1000);
    // R4 start, R3 fetch of descriptor 0
    wr(4'h5, 2'd0, 32'd2); wr(4'hB, 2'd0, 32'h15); wait_fetch();
    rd(4'h4, 0, "R4 cidx"); rd(4'hA, 1, "R4 pidx"); rd(4'h6, 0, "R4 halt clr");
    rd(4'h8, 5, "R3 count");
    // R5 completion with flag, R10 interrupt
    done_pulse(); wait_fetch();
    rd(4'h6, 32'h8, "R5 bd"); chk(irq == 1, "R10 irq rise", irq, 1);
    rd(4'h4, 1, "R6 adv"); rd(4'hA, 2, "R6 pidx"); rd(4'h8, 8, "R3 count1");
    wr(4'h6, 2'd0, 32'h08); rd(4'h6, 0, "R7 w1c"); chk(irq == 0, "R10 irq fall", irq, 0);
    // R6 reach last-valid
    done_pulse(); wait_fetch(); rd(4'h4, 2, "R6 idx2"); rd(4'h6, 0, "R5 no flag");
    done_pulse(); rd(4'h6, 32'h0F, "R6 last"); rd(4'h4, 2, "R6 hold");
    chk(irq == 1, "R10 lbd irq", irq, 1);
    // R11 halted ignores done
    done_pulse(); rd(4'h4, 2, "R11 halted");
    // R8 rewrite with equal index: no restart; then modulo and restart
    wr(4'h5, 2'd0, 32'd2); rd(4'h6, 32'h0F, "R8 no restart");
    wr(4'h5, 2'd0, 32'h25); rd(4'h5, 5, "R8 mod32"); rd(4'h6, 32'h0C, "R8 restart");
    rd(4'h4, 3, "R8 adv"); rd(4'hA, 4, "R8 pidx"); wait_fetch();
    wr(4'h6, 2'd0, 32'h0C); rd(4'h6, 0, "R7 w1c2");
    // R11 done during pending fetch
    done_pulse(); @(negedge clk); buf_done = 1; @(negedge clk); buf_done = 0;
    wait_fetch(); rd(4'h4, 4, "R11 pending");
    // R12 set and clear in the same cycle
    @(negedge clk); buf_done = 1; reg_we = 1; reg_addr = 4'h6; reg_size = 0; reg_wdata = 32'h08;
    @(negedge clk); buf_done = 0; reg_we = 0;
    rd(4'h6, 32'h08, "R12 set wins"); rd(4'h4, 5, "R12 adv"); wait_fetch();
    wr(4'h6, 2'd0, 32'h08);
    // R13 fifo error
    @(negedge clk); fifo_err = 1; @(negedge clk); fifo_err = 0;
    rd(4'h6, 32'h10, "R13 fe"); wr(4'h6, 2'd0, 32'h10); rd(4'h6, 0, "R7 fe clr");
    // R4 run clear
    wr(4'hB, 2'd0, 32'h14); rd(4'h6, 32'h01, "R4 halt");
    // R9 channel reset
    wr(4'hB, 2'd0, 32'h15); wait_fetch(); done_pulse();
    wr(4'hB, 2'd0, 32'h02);
    rd(4'h0, 0, "R9 base"); rd(4'h6, 32'h1, "R9 sts"); rd(4'hB, 0, "R9 ctl");
    rd(4'h5, 0, "R9 last"); rd(4'h8, 0, "R9 cnt"); chk(irq == 0, "R9 irq", irq, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule